// File: doc/BRIEF.md
# Second-Channel DMA Launch and Routing Register Block

This block is the register front end of a single DMA channel. Software programs a destination address and a byte length and then writes a start register. The block takes a snapshot of both values and hands them to a simple byte-stream master as a one-cycle request. It also works out which target window the destination falls in. When the master reports the end of the transfer, the block moves the destination register past the data it has just written. It then zeroes the length, drops the busy state and sets a bit in a normal interrupt status register. An interrupt line is raised while any unmasked status bit is set.

The destination is placed in one of the following classes:
- the tile-accelerator display-list window;
- the YUV converter window;
- one of two direct-memory windows. For these, a per-window mode bit picks either display-list traffic or texture traffic.
- unknown, for any other address.

The class chosen at launch can be read back and is presented to the master. Error conditions collect in a status register that software clears by writing ones. A sort-DMA start register is present but only acknowledges writes.

Top module: `dma2_regctl`

## Requirements
- R1: Writing 1 in bit 0 of START (word 2) while idle starts a transfer. One cycle later `xfer_start` is high for exactly one cycle, with `xfer_addr`/`xfer_len` equal to DEST (word 0) and LEN (word 1) as they were at the write. START reads 1 and ROUTE (word 8) bit 8 (busy) reads 1 until completion.
- R2: A `xfer_done` pulse while busy sets DEST to the launch address plus the launch length, and sets LEN and START to 0. It also clears busy.
- R3: Completion sets bit 0 of NSTAT (word 4). NSTAT clears on a write of 1 to a bit. `irq` is high when any bit of NSTAT AND NMASK (word 5) is 1.
- R4: Destinations 0x10000000..0x107FFFFF are routed as class 0 (tile-accelerator list), seen on `xfer_target` and in ROUTE bits 2:0.
- R5: Destinations 0x10800000..0x10FFFFFF are routed as class 1 (YUV converter).
- R6: Destinations 0x11000000..0x11FFFFFF are routed as class 2 (direct display list) when MODE (word 3) bit 0 is 1. Otherwise they are class 3 (direct texture).
- R7: Destinations 0x13000000..0x13FFFFFF follow the same rule as R6 but use MODE bit 1.
- R8: Any other destination is routed as class 7 (unknown), and the launch sets ERRSTAT (word 6) bit 1. ROUTE bits 2:0 read 7 after reset.
- R9: ERRSTAT clears exactly the bits written as 1. Completion with `xfer_err` high sets ERRSTAT bit 0.
- R10: A START write while busy is ignored. No new request is made, and completion uses the original launch values.
- R11: A write to SORT (word 7) is accepted without starting a transfer or changing any register. SORT reads 0.
- R12: A `xfer_done` pulse while idle changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word index |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` (combinational) |
| xfer_start | output | 1 | One-cycle transfer request |
| xfer_addr | output | DW | Destination of the request |
| xfer_len | output | DW | Byte length of the request |
| xfer_target | output | 3 | Routing class of the request |
| xfer_done | input | 1 | Transfer-finished pulse from the master |
| xfer_err | input | 1 | Error qualifier valid with `xfer_done` |
| irq | output | 1 | OR of masked normal status bits |

## Verification
A wrong busy state shows up within one cycle. Either a second `xfer_start` appears for a repeated start, or a completion pulse is accepted while idle and DEST moves. A bad launch snapshot or window boundary shows up in the cycle after the start write, on `xfer_addr`, `xfer_len` and `xfer_target`. A wrong completion update is visible in DEST, LEN and START right after the done pulse. Wrong clear masks appear at the next read of NSTAT or ERRSTAT and on `irq` in the same cycle.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

   typedef enum logic [2:0] {
      TGT_TA_LIST = 3'd0,
      TGT_YUV     = 3'd1,
      TGT_DLIST   = 3'd2,
      TGT_DTEX    = 3'd3,
      TGT_UNKNOWN = 3'd7
   } tgt_e;

   localparam int REG_DEST  = 0;
   localparam int REG_LEN   = 1;
   localparam int REG_START = 2;
   localparam int REG_MODE  = 3;
   localparam int REG_NSTAT = 4;
   localparam int REG_NMASK = 5;
   localparam int REG_ERR   = 6;
   localparam int REG_SORT  = 7;
   localparam int REG_ROUTE = 8;
   localparam int REG_COUNT = 9;

   localparam int BUSY_BIT  = 8;

endpackage

// File: rtl/dma2_route_decode.sv
module dma2_route_decode
   import dma2_pkg::*;
#(
   parameter int          DW        = 32,
   parameter logic [31:0] TA_LO     = 32'h1000_0000,
   parameter logic [31:0] TA_HI     = 32'h107F_FFFF,
   parameter logic [31:0] YUV_LO    = 32'h1080_0000,
   parameter logic [31:0] YUV_HI    = 32'h10FF_FFFF,
   parameter logic [31:0] DIRA_LO   = 32'h1100_0000,
   parameter logic [31:0] DIRB_LO   = 32'h1300_0000,
   parameter logic [31:0] DIR_SPAN  = 32'h0100_0000
)(
   input  logic [DW-1:0] addr_i,
   input  logic [1:0]    mode_i,
   output tgt_e          tgt_o
);

   localparam int NDIR = 2;
   localparam logic [31:0] DIR_LO [NDIR] = '{DIRA_LO, DIRB_LO};

   logic            hit_ta;
   logic            hit_yuv;
   logic [NDIR-1:0] hit_dir;
   logic [NDIR-1:0] dir_list;

   if (DW < 32) begin : g_bad_dw
      $error("dma2_route_decode: DW must be at least 32");
   end
   if (TA_HI >= YUV_LO) begin : g_bad_win
      $error("dma2_route_decode: windows overlap");
   end

   assign hit_ta  = (addr_i >= DW'(TA_LO))  && (addr_i <= DW'(TA_HI));
   assign hit_yuv = (addr_i >= DW'(YUV_LO)) && (addr_i <= DW'(YUV_HI));

   for (genvar g = 0; g < NDIR; g++) begin : g_dir
      assign hit_dir[g]  = (addr_i >= DW'(DIR_LO[g])) &&
                           (addr_i <= DW'(DIR_LO[g] + DIR_SPAN - 32'd1));
      assign dir_list[g] = mode_i[g];
   end

   always_comb begin
      tgt_o = TGT_UNKNOWN;
      if (hit_ta)
         tgt_o = TGT_TA_LIST;
      else if (hit_yuv)
         tgt_o = TGT_YUV;
      else
         for (int k = 0; k < NDIR; k++)
            if (hit_dir[k])
               tgt_o = dir_list[k] ? TGT_DLIST : TGT_DTEX;
   end

   always_comb begin
      AST_ONE_WINDOW: assert ($onehot0({hit_ta, hit_yuv, hit_dir})); // R8
   end

endmodule

// File: rtl/dma2_w1c_bank.sv
module dma2_w1c_bank #(
   parameter int W = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] set_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_bad_w
      $error("dma2_w1c_bank: W must be positive");
   end

   logic [W-1:0] clr;
   assign clr = wr_i ? wdata_i : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)
         q_o <= '0;
      else
         q_o <= (q_o & ~clr) | set_i;
   end

   AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i))); // R3

   AST_W1C_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && (set_i == '0)) |=> (q_o == ($past(q_o) & ~$past(wdata_i)))); // R9

endmodule

// File: rtl/dma2_chan.sv
module dma2_chan #(
   parameter int DW = 32
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dest_wr_i,
   input  logic          len_wr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          start_req_i,
   input  logic          done_i,
   output logic [DW-1:0] dest_o,
   output logic [DW-1:0] len_o,
   output logic          busy_o,
   output logic          launch_acc_o,
   output logic          done_acc_o,
   output logic          xfer_start_o,
   output logic [DW-1:0] xfer_addr_o,
   output logic [DW-1:0] xfer_len_o
);

   logic [DW-1:0] la_q;
   logic [DW-1:0] ll_q;

   assign launch_acc_o = start_req_i && !busy_o;
   assign done_acc_o   = done_i && busy_o;
   assign xfer_addr_o  = la_q;
   assign xfer_len_o   = ll_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dest_o       <= '0;
         len_o        <= '0;
         busy_o       <= 1'b0;
         xfer_start_o <= 1'b0;
         la_q         <= '0;
         ll_q         <= '0;
      end else begin
         xfer_start_o <= 1'b0;
         if (done_acc_o) begin
            dest_o <= la_q + ll_q;
            len_o  <= '0;
            busy_o <= 1'b0;
         end else begin
            if (dest_wr_i) dest_o <= wdata_i;
            if (len_wr_i)  len_o  <= wdata_i;
            if (launch_acc_o) begin
               busy_o       <= 1'b1;
               xfer_start_o <= 1'b1;
               la_q         <= dest_o;
               ll_q         <= len_o;
            end
         end
      end
   end

   AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start_o |-> busy_o); // R1

   AST_LAUNCH_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
      launch_acc_o |=> (xfer_addr_o == $past(dest_o) && xfer_len_o == $past(len_o))); // R1

   AST_DONE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      done_acc_o |=> (dest_o == $past(xfer_addr_o + xfer_len_o) && len_o == '0 && !busy_o)); // R2

   AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_i) |=> !xfer_start_o); // R10

   AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && done_i && !dest_wr_i && !len_wr_i) |=> ($stable(dest_o) && $stable(len_o))); // R12

endmodule

// File: rtl/dma2_regctl.sv
module dma2_regctl
   import dma2_pkg::*;
#(
   parameter int DW       = 32,
   parameter int AW       = 4,
   parameter int DONE_BIT = 0,
   parameter bit IRQ_REG  = 1'b0
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          xfer_start,
   output logic [DW-1:0] xfer_addr,
   output logic [DW-1:0] xfer_len,
   output logic [2:0]    xfer_target,
   input  logic          xfer_done,
   input  logic          xfer_err,
   output logic          irq
);

   localparam int ERR_XFER = 0;
   localparam int ERR_UNK  = 1;

   if ((1 << AW) < REG_COUNT) begin : g_bad_aw
      $error("dma2_regctl: AW too small for register map");
   end
   if (DONE_BIT >= DW || DW < 32) begin : g_bad_dw
      $error("dma2_regctl: bad DW or DONE_BIT");
   end

   logic [REG_COUNT-1:0] wsel;
   for (genvar r = 0; r < REG_COUNT; r++) begin : g_wsel
      assign wsel[r] = bus_wr && (bus_addr == AW'(r));
   end

   logic [DW-1:0] dest_q, len_q;
   logic          busy;
   logic          launch_acc, done_acc;
   logic [1:0]    mode_q;
   logic [DW-1:0] nmask_q;
   logic [DW-1:0] nstat_q, err_q;
   logic [DW-1:0] nstat_set, err_set;
   tgt_e          tgt_now;
   tgt_e          route_q;

   dma2_chan #(.DW(DW)) chan_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .dest_wr_i    (wsel[REG_DEST]),
      .len_wr_i     (wsel[REG_LEN]),
      .wdata_i      (bus_wdata),
      .start_req_i  (wsel[REG_START] && bus_wdata[0]),
      .done_i       (xfer_done),
      .dest_o       (dest_q),
      .len_o        (len_q),
      .busy_o       (busy),
      .launch_acc_o (launch_acc),
      .done_acc_o   (done_acc),
      .xfer_start_o (xfer_start),
      .xfer_addr_o  (xfer_addr),
      .xfer_len_o   (xfer_len)
   );

   dma2_route_decode #(.DW(DW)) dec_i (
      .addr_i (dest_q),
      .mode_i (mode_q),
      .tgt_o  (tgt_now)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= '0;
         nmask_q <= '0;
         route_q <= TGT_UNKNOWN;
      end else begin
         if (wsel[REG_MODE])  mode_q  <= bus_wdata[1:0];
         if (wsel[REG_NMASK]) nmask_q <= bus_wdata;
         if (launch_acc)      route_q <= tgt_now;
      end
   end

   assign xfer_target = route_q;

   always_comb begin
      nstat_set = '0;
      nstat_set[DONE_BIT] = done_acc;
      err_set = '0;
      err_set[ERR_XFER] = done_acc && xfer_err;
      err_set[ERR_UNK]  = launch_acc && (tgt_now == TGT_UNKNOWN);
   end

   dma2_w1c_bank #(.W(DW)) nstat_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wsel[REG_NSTAT]),
      .wdata_i (bus_wdata),
      .set_i   (nstat_set),
      .q_o     (nstat_q)
   );

   dma2_w1c_bank #(.W(DW)) err_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wsel[REG_ERR]),
      .wdata_i (bus_wdata),
      .set_i   (err_set),
      .q_o     (err_q)
   );

   logic irq_comb;
   assign irq_comb = |(nstat_q & nmask_q);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_comb;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_comb;
   end

   always_comb begin
      bus_rdata = '0;
      case (int'(bus_addr))
         REG_DEST:  bus_rdata = dest_q;
         REG_LEN:   bus_rdata = len_q;
         REG_START: bus_rdata[0] = busy;
         REG_MODE:  bus_rdata[1:0] = mode_q;
         REG_NSTAT: bus_rdata = nstat_q;
         REG_NMASK: bus_rdata = nmask_q;
         REG_ERR:   bus_rdata = err_q;
         REG_ROUTE: begin
            bus_rdata[2:0]      = route_q;
            bus_rdata[BUSY_BIT] = busy;
         end
         default:   bus_rdata = '0;
      endcase
   end

   AST_UNK_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_acc && tgt_now == TGT_UNKNOWN) |=> err_q[ERR_UNK]); // R8

   AST_ROUTE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      launch_acc |=> (xfer_target == $past(tgt_now))); // R4

   AST_SORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (wsel[REG_SORT] && !busy) |=> !xfer_start); // R11

   AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      done_acc |=> nstat_q[DONE_BIT]); // R3

endmodule

// File: tb/dma2_regctl_tb.sv
module dma2_regctl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        xfer_start;
   logic [31:0] xfer_addr;
   logic [31:0] xfer_len;
   logic [2:0]  xfer_target;
   logic        xfer_done = 1'b0;
   logic        xfer_err = 1'b0;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   dma2_regctl dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .xfer_start  (xfer_start),
      .xfer_addr   (xfer_addr),
      .xfer_len    (xfer_len),
      .xfer_target (xfer_target),
      .xfer_done   (xfer_done),
      .xfer_err    (xfer_err),
      .irq         (irq)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      bus_addr = 4'(a);
      #1 d = bus_rdata;
   endtask

   task automatic done_pulse(logic err);
      @(negedge clk);
      xfer_done = 1'b1; xfer_err = err;
      @(negedge clk);
      xfer_done = 1'b0; xfer_err = 1'b0;
   endtask

   task automatic launch_route(string req, logic [31:0] a, logic [1:0] m, logic [2:0] exp);
      logic [31:0] d;
      wr(3, {30'b0, m});
      wr(0, a);
      wr(1, 32'h10);
      wr(2, 32'h1);
      check({req, " start"}, {31'b0, xfer_start}, 32'h1);
      check({req, " class"}, {29'b0, xfer_target}, {29'b0, exp});
      rd(8, d);
      check({req, " route reg"}, d, {23'b0, 1'b1, 5'b0, exp});
      done_pulse(1'b0);
      wr(4, 32'h1);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int a = 0; a < 9; a++) begin
         rd(a, d);
         check("R8 reset reg", d, (a == 8) ? 32'h7 : 32'h0);
      end
      check("R3 reset irq", {31'b0, irq}, 32'h0);
      check("R1 reset start", {31'b0, xfer_start}, 32'h0);
   endtask

   task automatic t_basic();
      logic [31:0] d;
      wr(5, 32'h1);
      wr(0, 32'h1000_0000);
      wr(1, 32'h40);
      wr(2, 32'h1);
      check("R1 xfer_start", {31'b0, xfer_start}, 32'h1);
      check("R1 xfer_addr", xfer_addr, 32'h1000_0000);
      check("R1 xfer_len", xfer_len, 32'h40);
      check("R4 TA class", {29'b0, xfer_target}, 32'h0);
      rd(2, d);
      check("R1 START busy", d, 32'h1);
      @(negedge clk);
      check("R1 single pulse", {31'b0, xfer_start}, 32'h0);
      done_pulse(1'b0);
      rd(0, d); check("R2 dest advance", d, 32'h1000_0040);
      rd(1, d); check("R2 len cleared", d, 32'h0);
      rd(2, d); check("R2 start cleared", d, 32'h0);
      rd(8, d); check("R2 busy cleared", d & 32'h100, 32'h0);
      rd(4, d); check("R3 nstat set", d, 32'h1);
      check("R3 irq high", {31'b0, irq}, 32'h1);
      wr(5, 32'h0);
      check("R3 irq masked", {31'b0, irq}, 32'h0);
      wr(5, 32'h1);
      wr(4, 32'h1);
      rd(4, d); check("R3 nstat w1c", d, 32'h0);
      check("R3 irq cleared", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_windows();
      logic [31:0] d;
      launch_route("R4 TA top", 32'h107F_FFFF, 2'b00, 3'd0);
      launch_route("R5 YUV low", 32'h1080_0000, 2'b00, 3'd1);
      launch_route("R5 YUV top", 32'h10FF_FFFF, 2'b11, 3'd1);
      launch_route("R6 dirA tex", 32'h1100_0000, 2'b10, 3'd3);
      launch_route("R6 dirA list", 32'h11FF_FFFF, 2'b01, 3'd2);
      launch_route("R7 dirB list", 32'h13FF_FFFF, 2'b10, 3'd2);
      launch_route("R7 dirB tex", 32'h1300_0000, 2'b01, 3'd3);
      rd(6, d); check("R8 no err for known", d, 32'h0);
      launch_route("R8 gap", 32'h1200_0000, 2'b11, 3'd7);
      rd(6, d); check("R8 unknown err", d, 32'h2);
      wr(6, 32'h2);
      launch_route("R8 low", 32'h0C00_0000, 2'b00, 3'd7);
      wr(6, 32'h2);
   endtask

   task automatic t_err();
      logic [31:0] d;
      wr(0, 32'h0C00_0000);
      wr(1, 32'h4);
      wr(2, 32'h1);
      done_pulse(1'b1);
      rd(6, d); check("R9 both err bits", d, 32'h3);
      wr(6, 32'h2);
      rd(6, d); check("R9 partial clear", d, 32'h1);
      wr(6, 32'h0);
      rd(6, d); check("R9 zero write keeps", d, 32'h1);
      wr(6, 32'h1);
      rd(6, d); check("R9 full clear", d, 32'h0);
      wr(4, 32'h1);
   endtask

   task automatic t_busy();
      logic [31:0] d;
      wr(0, 32'h1080_0100);
      wr(1, 32'h20);
      wr(2, 32'h1);
      wr(0, 32'h1000_0000);
      wr(1, 32'h8);
      wr(2, 32'h1);
      check("R10 no restart", {31'b0, xfer_start}, 32'h0);
      check("R10 addr kept", xfer_addr, 32'h1080_0100);
      check("R10 class kept", {29'b0, xfer_target}, 32'h1);
      done_pulse(1'b0);
      rd(0, d); check("R10 completion uses first", d, 32'h1080_0120);
      wr(4, 32'h1);
   endtask

   task automatic t_sort_idle();
      logic [31:0] d;
      wr(0, 32'h1100_0040);
      wr(1, 32'h30);
      wr(7, 32'hFFFF_FFFF);
      check("R11 sort no start", {31'b0, xfer_start}, 32'h0);
      rd(7, d); check("R11 sort reads zero", d, 32'h0);
      rd(0, d); check("R11 dest unchanged", d, 32'h1100_0040);
      rd(1, d); check("R11 len unchanged", d, 32'h30);
      rd(8, d); check("R11 not busy", d & 32'h100, 32'h0);
      done_pulse(1'b1);
      rd(0, d); check("R12 idle done dest", d, 32'h1100_0040);
      rd(1, d); check("R12 idle done len", d, 32'h30);
      rd(4, d); check("R12 idle done nstat", d, 32'h0);
      rd(6, d); check("R12 idle done err", d, 32'h0);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_windows();
      t_err();
      t_busy();
      t_sort_idle();
      repeat (2) @(negedge clk);
      summary();
   end

endmodule